// File: doc/BRIEF.md
# Test-Port Trim Programming Sequencer

This block loads a short list of trim settings into a serial-link PHY. The PHY is reached only through an indirect test port. The port has a 14-bit command word driven toward the PHY and an 8-bit result byte returned from it. After one start pulse the sequencer walks a table of up to seven entries in table order. Each entry names a register, a bit range and a value.

For each entry the sequencer performs four steps:
- It reads the PHY register.
- It replaces only the named bit range in the byte it read.
- It writes the byte back with a low-high-low write-enable strobe.
- It reads the same register again and discards the result.

The PHY needs settling time after each change of the command word. For that reason, the first two result samples after every command update are thrown away. A legacy-mode input skips all programming. The block reports its progress with a busy level and a one-cycle done pulse. An error flag shows that the requested entry count was larger than the table and was cut down to fit.

Top module: `tprog_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `err_o` are 0 and `tin_o` is all zeros. `tin_o` stays at zero whenever the sequencer is idle.
- R2: The command word layout is:
  - data byte in bits 13:6;
  - register address in bits 5:1;
  - write-enable in bit 0.

  A read holds the word {data=1, address, write-enable=0} for three cycles. The first two result samples are discarded and the third is taken as the register's current value.
- R3: The byte written back is the read value with bits msb..lsb cleared, ORed with (value << lsb) masked to bits msb..lsb. Bits outside the range are unchanged, and value bits beyond the range width are dropped.
- R4: A write is three command updates carrying the same data and address, with write-enable 0, then 1, then 0. Each update is held for two cycles, which covers the two discarded samples. Each applied entry produces exactly one write-enable rising edge.
- R5: After the write, the command word {data=1, same address, write-enable=0} is held for three cycles and its sample is not used.
- R6: Entries are applied in table order, entry 0 first. Entry i occupies bits [i*5 +: 5] of `tbl_reg_i`, [i*3 +: 3] of `tbl_msb_i` and `tbl_lsb_i`, and [i*8 +: 8] of `tbl_val_i`. A later entry on the same register sees the result of an earlier one.
- R7: For a run of N applied entries, `busy_o` rises on the start edge and stays high for 12*N cycles. `done_o` is then high for exactly one cycle, with `busy_o` low.
- R8: When `legacy_i` is 1 at start, no command word changes, no write happens, and `done_o` pulses in the cycle after the start edge.
- R9: A count of 0 at start also gives an immediate done pulse with no command activity.
- R10: A count above 7 is clamped to 7. `err_o` is 1 from that start until the next accepted start. It is 0 after a start with a count of 7 or less.
- R11: A start pulse while `busy_o` is 1 is ignored. The count and legacy inputs are sampled only on an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only while idle |
| legacy_i | input | 1 | Skip programming when set at start |
| count_i | input | 4 | Number of table entries to apply |
| tbl_reg_i | input | 35 | Register address of each entry |
| tbl_msb_i | input | 21 | Upper bit of each entry's field |
| tbl_lsb_i | input | 21 | Lower bit of each entry's field |
| tbl_val_i | input | 56 | Value of each entry's field |
| tin_o | output | 14 | Command word toward the PHY test port |
| tout_i | input | 8 | Result byte from the PHY test port |
| busy_o | output | 1 | High while entries are being applied |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Count was clamped on the last accepted start |

## Verification
The bench runs the sequencer against a behavioural register-file model of the PHY. The model is preloaded with a known non-zero pattern, so every test shows whether bits outside a field survive the read-modify-write.

A three-entry table of narrow fields checks the basic phase timing and the word contents. A seven-entry table sent with an oversized count covers several cases at once:
- clamping;
- a full-byte field;
- a single-bit field;
- a value wider than its field;
- a register hit twice, where only the correct table order gives the right final byte.

Legacy mode, a zero count, and a start pulse injected in the middle of a run each tell a correct block apart from one that writes anyway or restarts.

// File: rtl/tprog_pkg.sv
package tprog_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;
    localparam int POS_W  = 3;
    localparam int TIN_W  = DATA_W + ADDR_W + 1;

    localparam logic [DATA_W-1:0] RD_TAG = DATA_W'(1);

    typedef enum logic [2:0] {
        PH_RD,
        PH_W0,
        PH_W1,
        PH_W2,
        PH_DR
    } phase_t;

    // Command word: data in 13:6, address in 5:1, write-enable in 0
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] addr;
        logic              wr;
    } tin_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [POS_W-1:0]  msb;
        logic [POS_W-1:0]  lsb;
        logic [DATA_W-1:0] val;
    } entry_t;

    // Last sub-cycle index of each phase: reads hold 3 cycles, writes 2
    function automatic logic [1:0] phase_last(input phase_t ph);
        return (ph == PH_RD || ph == PH_DR) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [DATA_W-1:0] field_mask(input logic [POS_W-1:0] msb,
                                                      input logic [POS_W-1:0] lsb);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++)
            m[i] = (i >= int'(lsb)) && (i <= int'(msb));
        return m;
    endfunction

endpackage

// File: rtl/tprog_entry_sel.sv
module tprog_entry_sel
    import tprog_pkg::*;
#(
    parameter int N_ENT = 7,
    parameter int IDX_W = 3
) (
    input  logic [N_ENT*ADDR_W-1:0] regs_i,
    input  logic [N_ENT*POS_W-1:0]  msbs_i,
    input  logic [N_ENT*POS_W-1:0]  lsbs_i,
    input  logic [N_ENT*DATA_W-1:0] vals_i,
    input  logic [IDX_W-1:0]        idx_i,
    output entry_t                  ent_o
);

    entry_t slots [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        assign slots[g].addr = regs_i[g*ADDR_W +: ADDR_W];
        assign slots[g].msb  = msbs_i[g*POS_W +: POS_W];
        assign slots[g].lsb  = lsbs_i[g*POS_W +: POS_W];
        assign slots[g].val  = vals_i[g*DATA_W +: DATA_W];
    end

    always_comb begin
        ent_o = '0;
        for (int i = 0; i < N_ENT; i++)
            if (idx_i == IDX_W'(i))
                ent_o = slots[i];
    end

endmodule

// File: rtl/tprog_merge.sv
module tprog_merge
    import tprog_pkg::*;
(
    input  logic [DATA_W-1:0] old_i,
    input  logic [POS_W-1:0]  msb_i,
    input  logic [POS_W-1:0]  lsb_i,
    input  logic [DATA_W-1:0] val_i,
    output logic [DATA_W-1:0] new_o
);

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        mask    = field_mask(msb_i, lsb_i);
        shifted = val_i << lsb_i;
        new_o   = (old_i & ~mask) | (shifted & mask);
    end

endmodule

// File: rtl/tprog_seq.sv
module tprog_seq
    import tprog_pkg::*;
#(
    parameter int MAX_ENT = 7,
    parameter int CNT_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic                      legacy_i,
    input  logic [CNT_W-1:0]          count_i,
    input  logic [MAX_ENT*ADDR_W-1:0] tbl_reg_i,
    input  logic [MAX_ENT*POS_W-1:0]  tbl_msb_i,
    input  logic [MAX_ENT*POS_W-1:0]  tbl_lsb_i,
    input  logic [MAX_ENT*DATA_W-1:0] tbl_val_i,
    output logic [TIN_W-1:0]          tin_o,
    input  logic [DATA_W-1:0]         tout_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      err_o
);

    localparam int IDX_W = $clog2(MAX_ENT + 1);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_ENT);

    logic             busy_q, done_q, err_q;
    logic [IDX_W-1:0] idx_q, last_q, sel_idx, n_clamp;
    logic [1:0]       sub_q;
    phase_t           phase_q;
    tin_t             tin_q;
    entry_t           ent;
    logic [DATA_W-1:0] merged;
    logic             finish;

    // During the dummy read the next entry is looked up ahead of time
    assign sel_idx = (busy_q && phase_q == PH_DR) ? idx_q + IDX_W'(1) : idx_q;
    assign n_clamp = (count_i > MAX_C) ? IDX_W'(MAX_ENT) : count_i[IDX_W-1:0];
    assign finish  = busy_q && phase_q == PH_DR && sub_q == 2'd2 && idx_q == last_q;

    tprog_entry_sel #(.N_ENT(MAX_ENT), .IDX_W(IDX_W)) u_sel (
        .regs_i (tbl_reg_i),
        .msbs_i (tbl_msb_i),
        .lsbs_i (tbl_lsb_i),
        .vals_i (tbl_val_i),
        .idx_i  (sel_idx),
        .ent_o  (ent)
    );

    tprog_merge u_merge (
        .old_i (tout_i),
        .msb_i (ent.msb),
        .lsb_i (ent.lsb),
        .val_i (ent.val),
        .new_o (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            idx_q   <= '0;
            last_q  <= '0;
            sub_q   <= '0;
            phase_q <= PH_RD;
            tin_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    err_q <= (count_i > MAX_C);
                    if (legacy_i || count_i == '0) begin
                        done_q <= 1'b1;
                    end else begin
                        busy_q  <= 1'b1;
                        idx_q   <= '0;
                        last_q  <= n_clamp - IDX_W'(1);
                        sub_q   <= '0;
                        phase_q <= PH_RD;
                        tin_q   <= '{data: RD_TAG, addr: ent.addr, wr: 1'b0};
                    end
                end
            end else if (sub_q != phase_last(phase_q)) begin
                sub_q <= sub_q + 2'd1;
            end else begin
                sub_q <= '0;
                unique case (phase_q)
                    PH_RD: begin
                        tin_q   <= '{data: merged, addr: ent.addr, wr: 1'b0};
                        phase_q <= PH_W0;
                    end
                    PH_W0: begin
                        tin_q.wr <= 1'b1;
                        phase_q  <= PH_W1;
                    end
                    PH_W1: begin
                        tin_q.wr <= 1'b0;
                        phase_q  <= PH_W2;
                    end
                    PH_W2: begin
                        tin_q   <= '{data: RD_TAG, addr: ent.addr, wr: 1'b0};
                        phase_q <= PH_DR;
                    end
                    PH_DR: begin
                        if (idx_q == last_q) begin
                            busy_q  <= 1'b0;
                            done_q  <= 1'b1;
                            idx_q   <= '0;
                            phase_q <= PH_RD;
                            tin_q   <= '0;
                        end else begin
                            idx_q   <= idx_q + IDX_W'(1);
                            phase_q <= PH_RD;
                            tin_q   <= '{data: RD_TAG, addr: ent.addr, wr: 1'b0};
                        end
                    end
                    default: phase_q <= PH_RD;
                endcase
            end
        end
    end

    assign tin_o  = tin_q;
    assign busy_o = busy_q;
    assign done_o = done_q;
    assign err_o  = err_q;

    // R1: idle command word is zero
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> tin_q == '0);

    // R2: read phase carries the read tag with write-enable low
    a_r2_read_word: assert property (@(posedge clk) disable iff (rst)
        (busy_q && phase_q == PH_RD) |-> (tin_q.data == RD_TAG && !tin_q.wr));

    // R4: strobe edges keep data and address unchanged
    a_r4_strobe_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(tin_q.wr) |-> tin_q[TIN_W-1:1] == $past(tin_q[TIN_W-1:1]));
    a_r4_strobe_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(tin_q.wr) |-> tin_q[TIN_W-1:1] == $past(tin_q[TIN_W-1:1]));

    // R7: done is a single cycle and never overlaps busy
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_q);

    // R11: a run is never cut short, start or not
    a_r11_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !finish) |=> busy_q);

    // R10: the error flag changes only on an accepted start
    a_r10_err_on_start: assert property (@(posedge clk) disable iff (rst)
        !$stable(err_q) |-> $past(start_i && !busy_q));

endmodule

// File: tb/tb_tprog_seq.sv
`timescale 1ns/1ps
module tb_tprog_seq;

    localparam int NE = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        legacy = 1'b0;
    logic [3:0]  count = '0;
    logic [NE*5-1:0] v_reg;
    logic [NE*3-1:0] v_msb, v_lsb;
    logic [NE*8-1:0] v_val;
    logic [13:0] tin;
    logic [7:0]  tout;
    logic        busy, done, err;

    logic [4:0] t_reg [NE];
    logic [2:0] t_msb [NE];
    logic [2:0] t_lsb [NE];
    logic [7:0] t_val [NE];

    logic [7:0] phy_mem [32];
    logic [7:0] sh [32];

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NE; i++) begin
            v_reg[i*5 +: 5] = t_reg[i];
            v_msb[i*3 +: 3] = t_msb[i];
            v_lsb[i*3 +: 3] = t_lsb[i];
            v_val[i*8 +: 8] = t_val[i];
        end
    end

    tprog_seq dut (
        .clk(clk), .rst(rst), .start_i(start), .legacy_i(legacy), .count_i(count),
        .tbl_reg_i(v_reg), .tbl_msb_i(v_msb), .tbl_lsb_i(v_lsb), .tbl_val_i(v_val),
        .tin_o(tin), .tout_i(tout), .busy_o(busy), .done_o(done), .err_o(err)
    );

    function automatic logic [7:0] init_b(input int a);
        return 8'hA5 ^ 8'(a * 29);
    endfunction

    // PHY register-file model: write while write-enable is high
    always @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < 32; a++) phy_mem[a] <= init_b(a);
        end else if (tin[0]) begin
            phy_mem[tin[5:1]] <= tin[13:6];
        end
    end
    assign tout = phy_mem[tin[5:1]];

    function automatic logic [7:0] ref_merge(input logic [7:0] old, input logic [2:0] msb,
                                             input logic [2:0] lsb, input logic [7:0] val);
        logic [15:0] sv;
        logic [7:0]  r;
        sv = {8'd0, val} << lsb;
        r = old;
        for (int b = 0; b < 8; b++)
            if (b >= int'(lsb) && b <= int'(msb)) r[b] = sv[b];
        return r;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic set_ent(input int i, input int r, input int m, input int l, input int v);
        t_reg[i] = 5'(r); t_msb[i] = 3'(m); t_lsb[i] = 3'(l); t_val[i] = 8'(v);
    endtask

    task automatic do_reset();
        rst = 1'b1; start = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_table(input int n_exp, input logic leg, input logic [3:0] cin,
                             input logic exp_err, input int inj);
        int strobes = 0, done_cnt = 0, done_at = -1, busy_bad = 0, busy_c = -1;
        logic prev_wr = 1'b0;
        logic [7:0] nb = '0;
        do_reset();
        for (int a = 0; a < 32; a++) sh[a] = init_b(a);
        start = 1'b1; legacy = leg; count = cin;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= 12 * n_exp + 3; c++) begin
            int e, off;
            logic [4:0] rg;
            if (c > 1) @(negedge clk);
            e = (c - 1) / 12; off = (c - 1) % 12;
            if (e < n_exp) begin
                rg = t_reg[e];
                if (off == 0) begin
                    nb = ref_merge(sh[rg], t_msb[e], t_lsb[e], t_val[e]);
                    sh[rg] = nb;
                    chk(tin == {8'd1, rg, 1'b0}, "R2 read word", tin, {8'd1, rg, 1'b0});
                end
                if (off == 3) chk(tin == {nb, rg, 1'b0}, "R4 write low", tin, {nb, rg, 1'b0});
                if (off == 5) chk(tin == {nb, rg, 1'b1}, "R4 write high", tin, {nb, rg, 1'b1});
                if (off == 7) chk(tin == {nb, rg, 1'b0}, "R4 write low again", tin, {nb, rg, 1'b0});
                if (off == 9) chk(tin == {8'd1, rg, 1'b0}, "R5 dummy read", tin, {8'd1, rg, 1'b0});
            end
            if (busy !== (c <= 12 * n_exp)) begin busy_bad++; busy_c = c; end
            if (done) begin done_cnt++; done_at = c; end
            if (tin[0] && !prev_wr) strobes++;
            prev_wr = tin[0];
            if (inj != 0 && c == inj) begin start = 1'b1; legacy = 1'b1; count = 4'd7; end
            if (inj != 0 && c == inj + 1) begin start = 1'b0; legacy = leg; count = cin; end
        end
        chk(done_cnt == 1 && done_at == 12 * n_exp + 1, "R7 done timing", done_at, 12 * n_exp + 1);
        chk(busy_bad == 0, "R7 busy profile", busy_c, 0);
        chk(strobes == n_exp, "R4 strobe count", strobes, n_exp);
        chk(err == exp_err, "R10 error flag", err, exp_err);
        chk(tin == 14'd0, "R1 idle word after run", tin, 0);
        for (int i = 0; i < NE; i++)
            chk(phy_mem[t_reg[i]] == sh[t_reg[i]], "R3 R6 register content",
                phy_mem[t_reg[i]], sh[t_reg[i]]);
    endtask

    task automatic load_three();
        for (int i = 0; i < NE; i++) set_ent(i, 20 + i, 7, 0, 8'h3C);
        set_ent(0, 7, 3, 0, 10);
        set_ent(1, 13, 6, 5, 2);
        set_ent(2, 26, 7, 4, 5);
    endtask

    task automatic test_reset();
        do_reset();
        chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R1 reset flags", {busy, done, err}, 0);
        chk(tin == 14'd0, "R1 reset word", tin, 0);
    endtask

    task automatic test_three();
        load_three();
        run_table(3, 1'b0, 4'd3, 1'b0, 0);     // R2 R3 R4 R5 R6 R7
    endtask

    task automatic test_seven_clamped();
        set_ent(0, 7, 3, 0, 10);
        set_ent(1, 9, 7, 0, 8'h5A);            // full byte field
        set_ent(2, 11, 4, 4, 1);               // single bit field
        set_ent(3, 13, 6, 5, 8'hFE);           // value wider than field
        set_ent(4, 27, 2, 0, 7);
        set_ent(5, 28, 1, 0, 1);
        set_ent(6, 7, 5, 2, 3);                // same register again: order matters (R6)
        run_table(7, 1'b0, 4'd9, 1'b1, 0);     // R10 clamp to 7
    endtask

    task automatic test_legacy();
        load_three();
        run_table(0, 1'b1, 4'd3, 1'b0, 0);     // R8
    endtask

    task automatic test_zero();
        load_three();
        run_table(0, 1'b0, 4'd0, 1'b0, 0);     // R9
    endtask

    task automatic test_restart();
        load_three();
        run_table(2, 1'b0, 4'd2, 1'b0, 5);     // R11 start mid-run ignored
    endtask

    initial begin
        for (int i = 0; i < NE; i++) set_ent(i, 0, 0, 0, 0);
        test_reset();
        test_three();
        test_seven_clamped();
        test_legacy();
        test_zero();
        test_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule